// File: doc/BRIEF.md
# Banked Group-1 Interrupt Enable Register Controller

This block holds the group-1 interrupt enable bit that a processor core's interrupt interface presents as a 32-bit system register. When the top privilege level (level 3) is built in, there are three one-bit copies of the enable: a secure copy, a non-secure copy and a virtual copy. Without level 3 there is one unbanked physical copy plus the virtual copy. For each access, the block is told the privilege level, the security state and a set of control and trap bits. From these it resolves whether the access is undefined, traps to level 2, traps to level 3, is redirected to the virtual copy, or reaches a physical copy.

The block answers every request one clock cycle after the strobe. The answer carries an outcome code, a syndrome value for traps and the read data. A write that is allowed updates the selected copy in that same cycle. When a physical enable falls from 1 to 0 while an interrupt of the matching security state is pending, the block raises a one-cycle release pulse so that the interrupt can be forwarded to another core. Instruction decode and exception entry are handled elsewhere.

Top module: `grpen_bank_ctrl`

## Requirements
- R1: The register is 32 bits wide. Only bit 0 holds state. A read returns bits 31:1 as zero, and bits 31:1 of write data have no effect.
- R2: The response appears in the cycle after the strobe, with rsp_valid high for one cycle. rsp_outcome takes these values: 0 ok, 1 undefined, 2 trap to level 2, 3 trap to level 3, 4 virtual. rsp_syndrome is 0x03 on both trap outcomes and 0 on every other outcome. rsp_rdata is zero for writes and for any outcome other than ok or virtual.
- R3: Every access at level 0 is undefined.
- R4: At level 1, the checks are made in the order below and the first match decides. The hypervisor bits count only while el2_on is 1. First, hyp_cp_trap gives a level-2 trap. Next, sre_l1 at 0 gives undefined. Then hyp_grp1_trap gives a level-2 trap. Then hyp_irq_virt sends the access to the virtual copy. If none of these match, the access reaches the copy chosen by req_ns (0 secure, 1 non-secure).
- R5: At level 1, when level 3 is built in, l3_irq_route is 1 and in_monitor is 0, the access traps to level 3. This check comes after the virtual redirect and before banking. With in_monitor at 1 the access is banked instead.
- R6: At level 2, sre_l2 at 0 gives undefined. Otherwise, when level 3 is built in, l3_irq_route gives a level-3 trap. Otherwise the access reaches the non-secure copy, whatever the value of req_ns.
- R7: At level 3, sre_l3 at 0 gives undefined. Otherwise req_ns selects the copy: 0 secure, 1 non-secure.
- R8: Without level 3 (HAS_L3 = 0), levels 1 and 2 share one physical copy, shown on en_nonsecure. en_secure stays 0, level-3 accesses are undefined and no level-3 trap occurs.
- R9: After reset, all enable copies are 0, and rsp_valid and irq_release are low.
- R10: A write that ends undefined or in a trap leaves every copy unchanged.
- R11: A virtual access reads or writes a separate virtual enable bit, shown on en_virtual.
- R12: irq_release pulses for one cycle, in the response cycle, when a write takes a physical copy from 1 to 0 while irq_pend is 1 and irq_pend_ns matches that copy (0 secure, 1 non-secure). In the unbanked build, any pending interrupt matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data |
| req_level | input | 2 | Privilege level of the access (0 to 3) |
| req_ns | input | 1 | Security state, 1 non-secure |
| el2_on | input | 1 | Level 2 enabled for this state |
| hyp_cp_trap | input | 1 | Hypervisor coprocessor-access trap bit |
| hyp_grp1_trap | input | 1 | Hypervisor trap-all-group-1 bit |
| hyp_irq_virt | input | 1 | Hypervisor IRQ override (virtual redirect) |
| sre_l1 | input | 1 | Level-1 system-register interface enable |
| sre_l2 | input | 1 | Level-2 system-register interface enable |
| sre_l3 | input | 1 | Level-3 system-register interface enable |
| l3_irq_route | input | 1 | IRQs routed to level 3 |
| in_monitor | input | 1 | Core is currently in monitor mode |
| irq_pend | input | 1 | An interrupt is pending in the interface |
| irq_pend_ns | input | 1 | Security state of the pending interrupt |
| rsp_valid | output | 1 | Response strobe |
| rsp_outcome | output | 3 | Resolved outcome code |
| rsp_syndrome | output | 6 | Trap syndrome |
| rsp_rdata | output | 32 | Read data |
| en_secure | output | 1 | Secure enable copy |
| en_nonsecure | output | 1 | Non-secure (or single) enable copy |
| en_virtual | output | 1 | Virtual enable copy |
| irq_release | output | 1 | Release pulse for a pending interrupt |

## Verification
The enable copies are shown directly on ports. A write that reaches the wrong copy, or that lands after an undefined or trap outcome, changes en_secure, en_nonsecure or en_virtual in the response cycle itself. A wrong priority decision in the resolver shows up at once as a wrong rsp_outcome or syndrome in that same response. Lost or duplicated state surfaces in the read data of the next read to that copy, and a mis-matched release shows as a missing or extra irq_release pulse in the response cycle. A model of both the banked and the unbanked build is checked against every response, so any error is reported in the cycle it first becomes visible.

// File: rtl/grpen_pkg.sv
`timescale 1ns/1ps
package grpen_pkg;

    localparam int REG_W     = 32;
    localparam int SYN_W     = 6;
    localparam int TRAP_CODE = 3;

    typedef enum logic [2:0] {
        OC_OK    = 3'd0,
        OC_UNDEF = 3'd1,
        OC_TRAP2 = 3'd2,
        OC_TRAP3 = 3'd3,
        OC_VIRT  = 3'd4
    } outcome_e;

    typedef enum logic [1:0] {
        TGT_SEC  = 2'd0,
        TGT_NSEC = 2'd1,
        TGT_VIRT = 2'd2,
        TGT_NONE = 2'd3
    } target_e;

    typedef struct packed {
        logic [1:0] level;
        logic       ns;
        logic       el2_on;
        logic       hyp_cp_trap;
        logic       hyp_grp1_trap;
        logic       hyp_irq_virt;
        logic       sre_l1;
        logic       sre_l2;
        logic       sre_l3;
        logic       l3_irq_route;
        logic       in_monitor;
    } ctx_t;

    typedef struct packed {
        outcome_e outcome;
        target_e  target;
    } verdict_t;

    function automatic logic reaches_copy(outcome_e o);
        return (o == OC_OK) || (o == OC_VIRT);
    endfunction

    function automatic logic is_trap(outcome_e o);
        return (o == OC_TRAP2) || (o == OC_TRAP3);
    endfunction

    function automatic target_e bank_of(logic ns);
        return ns ? TGT_NSEC : TGT_SEC;
    endfunction

endpackage

// File: rtl/grpen_resolve.sv
`timescale 1ns/1ps
module grpen_resolve
    import grpen_pkg::*;
#(
    parameter bit HAS_L3 = 1'b1
) (
    input  ctx_t     ctx,
    output verdict_t verdict
);

    localparam target_e PHYS_DEFAULT = TGT_NSEC;

    verdict_t v_l1, v_l2, v_l3;
    logic     hyp_cp, hyp_g1, hyp_virt, l3_route_hit;

    assign hyp_cp       = ctx.el2_on & ctx.hyp_cp_trap;
    assign hyp_g1       = ctx.el2_on & ctx.hyp_grp1_trap;
    assign hyp_virt     = ctx.el2_on & ctx.hyp_irq_virt;
    assign l3_route_hit = HAS_L3 & ctx.l3_irq_route;

    // level 1 priority chain
    always_comb begin
        v_l1 = '{outcome: OC_OK, target: TGT_NONE};
        if (hyp_cp) begin
            v_l1.outcome = OC_TRAP2;
        end else if (!ctx.sre_l1) begin
            v_l1.outcome = OC_UNDEF;
        end else if (hyp_g1) begin
            v_l1.outcome = OC_TRAP2;
        end else if (hyp_virt) begin
            v_l1 = '{outcome: OC_VIRT, target: TGT_VIRT};
        end else if (l3_route_hit && !ctx.in_monitor) begin
            v_l1.outcome = OC_TRAP3;
        end else begin
            v_l1.target = HAS_L3 ? bank_of(ctx.ns) : PHYS_DEFAULT;
        end
    end

    // level 2 priority chain
    always_comb begin
        v_l2 = '{outcome: OC_OK, target: TGT_NONE};
        if (!ctx.sre_l2) begin
            v_l2.outcome = OC_UNDEF;
        end else if (l3_route_hit) begin
            v_l2.outcome = OC_TRAP3;
        end else begin
            v_l2.target = PHYS_DEFAULT;
        end
    end

    // level 3 chain, absent when level 3 is not built
    generate
        if (HAS_L3) begin : g_l3
            always_comb begin
                if (!ctx.sre_l3) v_l3 = '{outcome: OC_UNDEF, target: TGT_NONE};
                else             v_l3 = '{outcome: OC_OK, target: bank_of(ctx.ns)};
            end
        end else begin : g_no_l3
            assign v_l3 = '{outcome: OC_UNDEF, target: TGT_NONE};
        end
    endgenerate

    always_comb begin
        unique case (ctx.level)
            2'd0:    verdict = '{outcome: OC_UNDEF, target: TGT_NONE};
            2'd1:    verdict = v_l1;
            2'd2:    verdict = v_l2;
            default: verdict = v_l3;
        endcase
    end

endmodule

// File: rtl/grpen_store.sv
`timescale 1ns/1ps
module grpen_store
    import grpen_pkg::*;
#(
    parameter bit HAS_L3 = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  target_e wr_tgt,
    input  logic    wr_bit,
    output logic    en_sec,
    output logic    en_nsec,
    output logic    en_virt,
    output logic    fall_sec,
    output logic    fall_nsec
);

    logic nsec_q, virt_q;

    generate
        if (HAS_L3) begin : g_sec
            logic sec_q;
            always_ff @(posedge clk) begin
                if (rst)                               sec_q <= 1'b0;
                else if (wr_en && wr_tgt == TGT_SEC)   sec_q <= wr_bit;
            end
            assign en_sec = sec_q;
        end else begin : g_no_sec
            assign en_sec = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            nsec_q <= 1'b0;
            virt_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_tgt == TGT_NSEC) nsec_q <= wr_bit;
            if (wr_tgt == TGT_VIRT) virt_q <= wr_bit;
        end
    end

    assign en_nsec   = nsec_q;
    assign en_virt   = virt_q;
    assign fall_sec  = wr_en && (wr_tgt == TGT_SEC)  && en_sec  && !wr_bit;
    assign fall_nsec = wr_en && (wr_tgt == TGT_NSEC) && en_nsec && !wr_bit;

endmodule

// File: rtl/grpen_release.sv
`timescale 1ns/1ps
module grpen_release #(
    parameter bit HAS_L3 = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_sec,
    input  logic fall_nsec,
    input  logic pend,
    input  logic pend_ns,
    output logic release_q
);

    logic ns_match, s_match, hit;

    assign ns_match = pend_ns | ~HAS_L3;
    assign s_match  = ~pend_ns;
    assign hit      = pend & ((fall_sec & s_match) | (fall_nsec & ns_match));

    always_ff @(posedge clk) begin
        if (rst) release_q <= 1'b0;
        else     release_q <= hit;
    end

endmodule

// File: rtl/grpen_bank_ctrl.sv
`timescale 1ns/1ps
module grpen_bank_ctrl
    import grpen_pkg::*;
#(
    parameter int DATA_W = grpen_pkg::REG_W,
    parameter int SYN_W  = grpen_pkg::SYN_W,
    parameter bit HAS_L3 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_level,
    input  logic              req_ns,
    input  logic              el2_on,
    input  logic              hyp_cp_trap,
    input  logic              hyp_grp1_trap,
    input  logic              hyp_irq_virt,
    input  logic              sre_l1,
    input  logic              sre_l2,
    input  logic              sre_l3,
    input  logic              l3_irq_route,
    input  logic              in_monitor,
    input  logic              irq_pend,
    input  logic              irq_pend_ns,
    output logic              rsp_valid,
    output logic [2:0]        rsp_outcome,
    output logic [SYN_W-1:0]  rsp_syndrome,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              en_secure,
    output logic              en_nonsecure,
    output logic              en_virtual,
    output logic              irq_release
);

    localparam logic [SYN_W-1:0] TRAP_SYN = SYN_W'(TRAP_CODE);

    ctx_t        ctx;
    verdict_t    verdict;
    logic        commit, cur_bit, fall_sec, fall_nsec;
    logic        wdata_unused;
    logic [DATA_W-1:0] rd_next;

    assign ctx = '{
        level:         req_level,
        ns:            req_ns,
        el2_on:        el2_on,
        hyp_cp_trap:   hyp_cp_trap,
        hyp_grp1_trap: hyp_grp1_trap,
        hyp_irq_virt:  hyp_irq_virt,
        sre_l1:        sre_l1,
        sre_l2:        sre_l2,
        sre_l3:        sre_l3,
        l3_irq_route:  l3_irq_route,
        in_monitor:    in_monitor
    };

    grpen_resolve #(.HAS_L3(HAS_L3)) u_resolve (
        .ctx     (ctx),
        .verdict (verdict)
    );

    assign commit       = req_valid && req_write && reaches_copy(verdict.outcome);
    assign wdata_unused = ^req_wdata[DATA_W-1:1];

    grpen_store #(.HAS_L3(HAS_L3)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (commit),
        .wr_tgt    (verdict.target),
        .wr_bit    (req_wdata[0]),
        .en_sec    (en_secure),
        .en_nsec   (en_nonsecure),
        .en_virt   (en_virtual),
        .fall_sec  (fall_sec),
        .fall_nsec (fall_nsec)
    );

    grpen_release #(.HAS_L3(HAS_L3)) u_release (
        .clk       (clk),
        .rst       (rst),
        .fall_sec  (fall_sec),
        .fall_nsec (fall_nsec),
        .pend      (irq_pend),
        .pend_ns   (irq_pend_ns),
        .release_q (irq_release)
    );

    always_comb begin
        unique case (verdict.target)
            TGT_SEC:  cur_bit = en_secure;
            TGT_NSEC: cur_bit = en_nonsecure;
            TGT_VIRT: cur_bit = en_virtual;
            default:  cur_bit = 1'b0;
        endcase
        rd_next = '0;
        if (!req_write && reaches_copy(verdict.outcome)) rd_next[0] = cur_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_outcome  <= OC_OK;
            rsp_syndrome <= '0;
            rsp_rdata    <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_outcome  <= verdict.outcome;
                rsp_syndrome <= is_trap(verdict.outcome) ? TRAP_SYN : '0;
                rsp_rdata    <= rd_next;
            end
        end
    end

endmodule

// File: rtl/grpen_bank_ctrl_chk.sv
`timescale 1ns/1ps
module grpen_bank_ctrl_chk
    import grpen_pkg::*;
#(
    parameter int DATA_W = grpen_pkg::REG_W,
    parameter int SYN_W  = grpen_pkg::SYN_W,
    parameter bit HAS_L3 = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_level,
    input logic              rsp_valid,
    input logic [2:0]        rsp_outcome,
    input logic [SYN_W-1:0]  rsp_syndrome,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              en_secure,
    input logic              en_nonsecure,
    input logic              en_virtual,
    input logic              irq_release
);

    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_trap_syndrome_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_outcome == OC_TRAP2 || rsp_outcome == OC_TRAP3))
        |-> rsp_syndrome == SYN_W'(TRAP_CODE));

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_rdata[DATA_W-1:1] == '0);

    p_level0_undef_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_level == 2'd0) |=> rsp_outcome == OC_UNDEF);

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!en_secure && !en_nonsecure && !en_virtual && !irq_release));

    p_fail_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_outcome == OC_UNDEF || rsp_outcome == OC_TRAP2 ||
                       rsp_outcome == OC_TRAP3))
        |-> ($stable(en_secure) && $stable(en_nonsecure) && $stable(en_virtual)));

    p_release_fall_r12: assert property (@(posedge clk) disable iff (rst)
        irq_release |-> (($past(en_secure) && !en_secure) ||
                         ($past(en_nonsecure) && !en_nonsecure)));

    p_release_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        irq_release |-> rsp_valid);

endmodule

bind grpen_bank_ctrl grpen_bank_ctrl_chk #(
    .DATA_W (DATA_W),
    .SYN_W  (SYN_W),
    .HAS_L3 (HAS_L3)
) u_chk (.*);

// File: tb/grpen_bank_ctrl_bench.sv
`timescale 1ns/1ps
module grpen_bank_ctrl_bench;

    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_ns = 1'b0;
    logic [W-1:0] req_wdata = '0;
    logic [1:0]   req_level = 2'd0;
    logic el2_on = 1'b1, hyp_cp_trap = 1'b0, hyp_grp1_trap = 1'b0, hyp_irq_virt = 1'b0;
    logic sre_l1 = 1'b1, sre_l2 = 1'b1, sre_l3 = 1'b1;
    logic l3_irq_route = 1'b0, in_monitor = 1'b0, irq_pend = 1'b0, irq_pend_ns = 1'b0;

    logic         rsp_valid, en_secure, en_nonsecure, en_virtual, irq_release;
    logic [2:0]   rsp_outcome;
    logic [5:0]   rsp_syndrome;
    logic [W-1:0] rsp_rdata;
    logic         rsp_valid_b, en_secure_b, en_nonsecure_b, en_virtual_b, irq_release_b;
    logic [2:0]   rsp_outcome_b;
    logic [5:0]   rsp_syndrome_b;
    logic [W-1:0] rsp_rdata_b;

    always #10 clk = ~clk;

    grpen_bank_ctrl u_grpen_bank_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_wdata(req_wdata), .req_level(req_level), .req_ns(req_ns),
        .el2_on(el2_on), .hyp_cp_trap(hyp_cp_trap), .hyp_grp1_trap(hyp_grp1_trap),
        .hyp_irq_virt(hyp_irq_virt), .sre_l1(sre_l1), .sre_l2(sre_l2), .sre_l3(sre_l3),
        .l3_irq_route(l3_irq_route), .in_monitor(in_monitor), .irq_pend(irq_pend),
        .irq_pend_ns(irq_pend_ns), .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
        .rsp_syndrome(rsp_syndrome), .rsp_rdata(rsp_rdata), .en_secure(en_secure),
        .en_nonsecure(en_nonsecure), .en_virtual(en_virtual), .irq_release(irq_release)
    );

    grpen_bank_ctrl #(.HAS_L3(1'b0)) u_grpen_bank_ctrl_flat (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_wdata(req_wdata), .req_level(req_level), .req_ns(req_ns),
        .el2_on(el2_on), .hyp_cp_trap(hyp_cp_trap), .hyp_grp1_trap(hyp_grp1_trap),
        .hyp_irq_virt(hyp_irq_virt), .sre_l1(sre_l1), .sre_l2(sre_l2), .sre_l3(sre_l3),
        .l3_irq_route(l3_irq_route), .in_monitor(in_monitor), .irq_pend(irq_pend),
        .irq_pend_ns(irq_pend_ns), .rsp_valid(rsp_valid_b), .rsp_outcome(rsp_outcome_b),
        .rsp_syndrome(rsp_syndrome_b), .rsp_rdata(rsp_rdata_b), .en_secure(en_secure_b),
        .en_nonsecure(en_nonsecure_b), .en_virtual(en_virtual_b), .irq_release(irq_release_b)
    );

    typedef struct {
        string       tag;
        logic [44:0] ea;
        logic [44:0] eb;
    } item_t;

    item_t q[$];
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model state: banked build (s, ns, v), flat build (single, v)
    logic m_s = 1'b0, m_ns = 1'b0, m_v = 1'b0, f_one = 1'b0, f_v = 1'b0;

    // returns {outcome[2:0], target[1:0]}; target 0 sec, 1 nsec, 2 virt, 3 none
    function automatic logic [4:0] mdl(bit l3, logic [1:0] lvl, logic ns);
        if (lvl == 2'd0) return {3'd1, 2'd3};
        if (lvl == 2'd1) begin
            if (el2_on && hyp_cp_trap)          return {3'd2, 2'd3};
            if (!sre_l1)                        return {3'd1, 2'd3};
            if (el2_on && hyp_grp1_trap)        return {3'd2, 2'd3};
            if (el2_on && hyp_irq_virt)         return {3'd4, 2'd2};
            if (l3 && l3_irq_route && !in_monitor) return {3'd3, 2'd3};
            return {3'd0, (l3 ? {1'b0, ns} : 2'd1)};
        end
        if (lvl == 2'd2) begin
            if (!sre_l2)                return {3'd1, 2'd3};
            if (l3 && l3_irq_route)     return {3'd3, 2'd3};
            return {3'd0, 2'd1};
        end
        if (!l3 || !sre_l3) return {3'd1, 2'd3};
        return {3'd0, {1'b0, ns}};
    endfunction

    function automatic logic [44:0] pack(logic [2:0] oc, logic [W-1:0] rd,
                                         logic s, logic n, logic v, logic rel);
        logic [5:0] syn;
        syn = (oc == 3'd2 || oc == 3'd3) ? 6'h03 : 6'h00;
        return {oc, syn, rd, s, n, v, rel};
    endfunction

    task automatic access(string tag, bit wr, logic [W-1:0] wd, logic [1:0] lvl, bit ns);
        item_t it;
        logic [4:0] va, vb;
        logic okv, cur, rel;
        logic [W-1:0] rd;
        va = mdl(1'b1, lvl, ns);
        vb = mdl(1'b0, lvl, ns);
        // banked build
        okv = (va[4:2] == 3'd0) || (va[4:2] == 3'd4);
        cur = (va[1:0] == 2'd0) ? m_s : (va[1:0] == 2'd1) ? m_ns : (va[1:0] == 2'd2) ? m_v : 1'b0;
        rd  = (!wr && okv) ? {{(W-1){1'b0}}, cur} : '0;
        rel = wr && okv && cur && !wd[0] && irq_pend &&
              ((va[1:0] == 2'd0 && !irq_pend_ns) || (va[1:0] == 2'd1 && irq_pend_ns));
        if (wr && okv) begin
            if (va[1:0] == 2'd0) m_s  = wd[0];
            if (va[1:0] == 2'd1) m_ns = wd[0];
            if (va[1:0] == 2'd2) m_v  = wd[0];
        end
        it.ea = pack(va[4:2], rd, m_s, m_ns, m_v, rel);
        // flat build
        okv = (vb[4:2] == 3'd0) || (vb[4:2] == 3'd4);
        cur = (vb[1:0] == 2'd1) ? f_one : (vb[1:0] == 2'd2) ? f_v : 1'b0;
        rd  = (!wr && okv) ? {{(W-1){1'b0}}, cur} : '0;
        rel = wr && okv && cur && !wd[0] && irq_pend && (vb[1:0] == 2'd1);
        if (wr && okv) begin
            if (vb[1:0] == 2'd1) f_one = wd[0];
            if (vb[1:0] == 2'd2) f_v   = wd[0];
        end
        it.eb  = pack(vb[4:2], rd, 1'b0, f_one, f_v, rel);
        it.tag = tag;
        q.push_back(it);
        req_valid = 1'b1; req_write = wr; req_wdata = wd; req_level = lvl; req_ns = ns;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && (rsp_valid || rsp_valid_b)) begin
            logic [44:0] aa, ab;
            item_t it;
            aa = {rsp_outcome, rsp_syndrome, rsp_rdata, en_secure, en_nonsecure, en_virtual, irq_release};
            ab = {rsp_outcome_b, rsp_syndrome_b, rsp_rdata_b, en_secure_b, en_nonsecure_b, en_virtual_b, irq_release_b};
            checks += 2;
            if (q.size() == 0) begin
                errors += 2;
                $display("FAIL R2 unexpected response: actual=%h/%h expected=none", aa, ab);
            end else begin
                it = q.pop_front();
                if (!rsp_valid || aa !== it.ea) begin
                    errors++;
                    $display("FAIL %s banked: actual=%h expected=%h", it.tag, aa, it.ea);
                end
                if (!rsp_valid_b || ab !== it.eb) begin
                    errors++;
                    $display("FAIL %s flat: actual=%h expected=%h", it.tag, ab, it.eb);
                end
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R2 watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state of both builds
        checks++;
        if ({rsp_valid, en_secure, en_nonsecure, en_virtual, irq_release,
             rsp_valid_b, en_secure_b, en_nonsecure_b, en_virtual_b, irq_release_b} !== 10'b0) begin
            errors++;
            $display("FAIL R9 reset: actual=%b expected=0",
                {rsp_valid, en_secure, en_nonsecure, en_virtual, irq_release,
                 rsp_valid_b, en_secure_b, en_nonsecure_b, en_virtual_b, irq_release_b});
        end

        access("R7 l3 secure write",      1, 32'h1, 2'd3, 0);
        access("R1 upper bits ignored",   1, 32'hFFFF_FFFE, 2'd3, 1);
        access("R1 read ns zero",         0, 32'h0, 2'd3, 1);
        access("R7 read secure",          0, 32'h0, 2'd3, 0);
        access("R4 l1 banked ns write",   1, 32'h1, 2'd1, 1);
        access("R4 l1 banked s read",     0, 32'h0, 2'd1, 0);
        access("R3 level0 write",         1, 32'h0, 2'd0, 1);
        access("R3 level0 read",          0, 32'h0, 2'd0, 0);

        hyp_cp_trap = 1; sre_l1 = 0;
        access("R4 cp trap before undef", 1, 32'h0, 2'd1, 1);
        el2_on = 0;
        access("R4 cp trap gated el2",    1, 32'h0, 2'd1, 1);
        el2_on = 1; hyp_cp_trap = 0; hyp_grp1_trap = 1;
        access("R4 sre undef before g1",  1, 32'h0, 2'd1, 1);
        sre_l1 = 1; hyp_irq_virt = 1;
        access("R10 g1 trap no write",    1, 32'h0, 2'd1, 0);
        hyp_grp1_trap = 0; l3_irq_route = 1;
        access("R11 virtual write",       1, 32'h1, 2'd1, 1);
        access("R11 virtual read",        0, 32'h0, 2'd1, 0);
        el2_on = 0;
        access("R5 l3 route trap",        1, 32'h0, 2'd1, 1);
        in_monitor = 1;
        access("R5 monitor banks",        0, 32'h0, 2'd1, 0);
        in_monitor = 0; el2_on = 1; hyp_irq_virt = 0;
        access("R6 l2 route trap",        0, 32'h0, 2'd2, 1);
        sre_l2 = 0;
        access("R6 l2 undef",             1, 32'h0, 2'd2, 1);
        sre_l2 = 1; l3_irq_route = 0;
        irq_pend = 1; irq_pend_ns = 1;
        access("R12 l2 ns clear release", 1, 32'h0, 2'd2, 0);
        access("R6 l2 reads ns copy",     0, 32'h0, 2'd2, 0);
        access("R12 s clear ns pending",  1, 32'h0, 2'd3, 0);
        access("R8 l3 write",             1, 32'h1, 2'd3, 0);
        irq_pend_ns = 0;
        access("R12 s clear s pending",   1, 32'h0, 2'd3, 0);
        access("R12 no fall no release",  1, 32'h0, 2'd3, 0);
        sre_l3 = 0;
        access("R7 l3 undef",             1, 32'h1, 2'd3, 1);
        sre_l3 = 1; irq_pend = 0;
        access("R8 l1 single copy",       1, 32'h1, 2'd1, 0);
        access("R8 l2 single read",       0, 32'h0, 2'd2, 1);
        access("R12 clear no pending",    1, 32'h0, 2'd1, 1);

        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing responses: actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule